// File: doc/BRIEF.md
# Memory Traffic Generator and Checker

This block exercises a simple synchronous memory port. After a start strobe it runs test iterations over a programmable count of consecutive addresses that begin at zero. A write pass stores words from a selectable data source. A read pass fetches the same words back and compares each returned word with the same data rebuilt on the read side. Iterations repeat until a stop strobe arrives. The mode chosen at start decides which passes run.

Two counters track detected mismatches and injected corruptions. A clear strobe zeroes both. A request input corrupts exactly one outgoing write word. Two saturating counters total the bytes written and the bytes read, so that throughput can be worked out outside the block. Writes and reads both wait on a ready input from the memory. A returned read word counts only on a cycle where its valid flag is high.

Top module: `mem_traffic_gen`

## Requirements
- R1: After reset, and in every cycle while idle, `busy_o`, `mem_we_o` and `mem_rd_o` are low. All four counters read zero after reset.
- R2: The count of addresses per pass is taken from `num_addr_i` at start. A value below 8 is treated as 8, and a value above 16,777,216 is treated as 16,777,216. Each pass uses addresses 0 up to count−1 in ascending order.
- R3: Pattern code 0 (and code 3) is a 31-bit LFSR with next state `{s[29:0], s[30]^s[27]}` and seed 31'h2A5A1234. The seed is loaded for the first word of every pass, and each later word steps once. The 36-bit word is `{s[4:0], s}`.
- R4: Pattern code 1 is a 16-entry table indexed by address bits [3:0]. Entry i holds `{9{i[3:0]}} ^ 36'h596A3C0F1`.
- R5: Pattern code 2 is the zero-extended address plus 36'h9C3A50011, taken modulo 2^36.
- R6: Mode 0 (and mode 3) alternates a write pass and a read pass. Mode 1 repeats read passes only. Mode 2 repeats write passes only. The write strobe and the read strobe are never high together.
- R7: A write beat or a read request that sees `mem_ready_i` low keeps its strobe, address and (for writes) data unchanged in the next cycle, unless stop is asserted.
- R8: In a read pass, each beat with `mem_rvalid_i` high is compared against the expected word of the next address in order. Each mismatch adds one to `err_detect_o`. Valid beats outside a read pass change no counter.
- R9: An insert request during a run that includes writes adds one to `err_insert_cnt_o` at once. It also inverts bit 0 of the next accepted write word, and only that word. A read-back of that word adds exactly one detected error. While an insertion is pending, or while a write is stalled, further requests are ignored.
- R10: An insert request while idle changes no counter and corrupts no later write.
- R11: `clear_i` sets `err_detect_o` and `err_insert_cnt_o` to zero in the next cycle, taking priority over any increment.
- R12: `bytes_wr_o` and `bytes_rd_o` return to zero at start. They add 4 per accepted write beat or counted read beat, and they saturate at their all-ones value.
- R13: `start_i` while idle begins a run and raises `busy_o`, and while busy it is ignored. `stop_i` returns the block to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a run (idle only) |
| stop_i | input | 1 | End the run |
| mode_i | input | 2 | Transaction mode, latched at start |
| pat_sel_i | input | 2 | Data source select, latched at start |
| num_addr_i | input | ADDR_W+1 | Addresses per pass, latched at start |
| err_insert_i | input | 1 | Request one corrupted write word |
| clear_i | input | 1 | Zero both error counters |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 36 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_rd_o | output | 1 | Read request |
| mem_ready_i | input | 1 | Memory accepts the current write or read |
| mem_rdata_i | input | 36 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Run active |
| err_detect_o | output | ERR_W | Detected mismatch count |
| err_insert_cnt_o | output | ERR_W | Injected corruption count |
| bytes_wr_o | output | BYTE_W | Bytes written since start |
| bytes_rd_o | output | BYTE_W | Bytes read since start |

## Verification
The assertions watch, on every cycle, that the port is quiet while idle and that the write and read strobes never overlap. They also check that a stalled beat holds its address and data, that the latched address count stays within range, that the insert counter moves by at most one, and that clear and idle requests act as specified. Several behaviours can only be shown by the bench's scenarios, because they need a memory with contents and a model of the expected data. These are the word values of each data source, the reseed at each pass, the one-word scope of an injection and its single read-back mismatch, the mismatch count when the read source differs from the written one, the address clamp, and byte-counter saturation.

// File: rtl/mtg_pkg.sv
`timescale 1ns/1ps
package mtg_pkg;

    localparam int DATA_W    = 36;
    localparam int LFSR_W    = 31;
    localparam int MIN_ADDRS = 8;

    localparam logic [LFSR_W-1:0] LFSR_SEED = 31'h2A5A1234;
    localparam logic [DATA_W-1:0] TBL_MASK  = 36'h5_96A3_C0F1;
    localparam logic [DATA_W-1:0] ARITH_K   = 36'h9_C3A5_0011;

    typedef enum logic [1:0] {
        MODE_WR_RD   = 2'd0,
        MODE_RD_ONLY = 2'd1,
        MODE_WR_ONLY = 2'd2,
        MODE_ALT     = 2'd3
    } mtg_mode_e;

    typedef enum logic [1:0] {
        SRC_LFSR  = 2'd0,
        SRC_TABLE = 2'd1,
        SRC_ARITH = 2'd2,
        SRC_ALT   = 2'd3
    } mtg_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } mtg_state_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[30] ^ s[27]};
    endfunction

    function automatic logic [DATA_W-1:0] lfsr_word(input logic [LFSR_W-1:0] s);
        return {s[4:0], s};
    endfunction

    function automatic logic [DATA_W-1:0] table_word(input logic [3:0] idx);
        return {9{idx}} ^ TBL_MASK;
    endfunction

    function automatic logic [DATA_W-1:0] arith_word(input logic [DATA_W-1:0] a);
        return a + ARITH_K;
    endfunction

    function automatic logic mode_has_writes(input mtg_mode_e m);
        return m != MODE_RD_ONLY;
    endfunction

    function automatic logic mode_has_reads(input mtg_mode_e m);
        return m != MODE_WR_ONLY;
    endfunction

endpackage

// File: rtl/mtg_pattern_gen.sv
`timescale 1ns/1ps
module mtg_pattern_gen
    import mtg_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    input  mtg_src_e          src,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);

    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            lfsr_q <= LFSR_SEED;
        end else if (advance) begin
            lfsr_q <= lfsr_step(lfsr_q);
        end
    end

    always_comb begin
        case (src)
            SRC_TABLE: word = table_word(addr[3:0]);
            SRC_ARITH: word = arith_word(DATA_W'(addr));
            default:   word = lfsr_word(lfsr_q);
        endcase
    end

    // R3: the sequence state is always a non-zero LFSR value
    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/mtg_sat_counter.sv
`timescale 1ns/1ps
module mtg_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] amount,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            if (count > TOP - amount) begin
                count <= TOP;
            end else begin
                count <= count + amount;
            end
        end
    end

    // R12: a counter never wraps downward unless cleared
    a_r12_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr |=> count >= $past(count));

endmodule

// File: rtl/mem_traffic_gen.sv
`timescale 1ns/1ps
module mem_traffic_gen
    import mtg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ERR_W  = 32,
    parameter int BYTE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic [1:0]          mode_i,
    input  logic [1:0]          pat_sel_i,
    input  logic [ADDR_W:0]     num_addr_i,
    input  logic                err_insert_i,
    input  logic                clear_i,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [DATA_W-1:0]   mem_wdata_o,
    output logic                mem_we_o,
    output logic                mem_rd_o,
    input  logic                mem_ready_i,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    input  logic                mem_rvalid_i,
    output logic                busy_o,
    output logic [ERR_W-1:0]    err_detect_o,
    output logic [ERR_W-1:0]    err_insert_cnt_o,
    output logic [BYTE_W-1:0]   bytes_wr_o,
    output logic [BYTE_W-1:0]   bytes_rd_o
);

    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0]  MIN_N      = CNT_W'(MIN_ADDRS);
    localparam logic [CNT_W-1:0]  MAX_N      = CNT_W'(1) << ADDR_W;
    localparam logic [BYTE_W-1:0] BEAT_BYTES = BYTE_W'(DATA_W / 8);
    localparam logic [ERR_W-1:0]  ONE_ERR    = ERR_W'(1);

    mtg_state_e       state_q, state_n;
    mtg_mode_e        mode_q;
    mtg_src_e         src_q;
    logic [CNT_W-1:0] num_q;
    logic [CNT_W-1:0] wr_cnt_q, rd_iss_q, rd_rcv_q;
    logic             inj_pend_q;

    logic             wr_restart, rd_restart;
    logic             start_ok, wr_fire, rd_fire, rv_beat;
    logic             wr_last, rd_last, inj_take, mismatch;
    logic [DATA_W-1:0] wr_word, rd_word;
    logic [CNT_W-1:0] num_clamped;

    // ---------------- handshake and pass bookkeeping ----------------
    assign start_ok = (state_q == ST_IDLE) && start_i;
    assign mem_we_o = (state_q == ST_WRITE);
    assign mem_rd_o = (state_q == ST_READ) && (rd_iss_q < num_q);
    assign wr_fire  = mem_we_o && mem_ready_i;
    assign rd_fire  = mem_rd_o && mem_ready_i;
    assign rv_beat  = (state_q == ST_READ) && mem_rvalid_i && (rd_rcv_q < num_q);
    assign wr_last  = wr_fire && (wr_cnt_q == num_q - 1'b1);
    assign rd_last  = rv_beat && (rd_rcv_q == num_q - 1'b1);
    assign busy_o   = (state_q != ST_IDLE);

    assign mem_addr_o = mem_we_o ? wr_cnt_q[ADDR_W-1:0] : rd_iss_q[ADDR_W-1:0];

    always_comb begin
        if (num_addr_i < MIN_N) begin
            num_clamped = MIN_N;
        end else if (num_addr_i > MAX_N) begin
            num_clamped = MAX_N;
        end else begin
            num_clamped = num_addr_i;
        end
    end

    always_comb begin
        state_n    = state_q;
        wr_restart = 1'b0;
        rd_restart = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (mode_has_writes(mtg_mode_e'(mode_i))) begin
                        state_n    = ST_WRITE;
                        wr_restart = 1'b1;
                    end else begin
                        state_n    = ST_READ;
                        rd_restart = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (wr_last) begin
                    if (mode_has_reads(mode_q)) begin
                        state_n    = ST_READ;
                        rd_restart = 1'b1;
                    end else begin
                        wr_restart = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (rd_last) begin
                    if (mode_has_writes(mode_q)) begin
                        state_n    = ST_WRITE;
                        wr_restart = 1'b1;
                    end else begin
                        rd_restart = 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (stop_i && state_q != ST_IDLE) begin
            state_n    = ST_IDLE;
            wr_restart = 1'b0;
            rd_restart = 1'b0;
        end
    end

    // an insert request is taken only in a run with writes, not while one
    // is pending, and never while a write beat is stalled
    assign inj_take = err_insert_i && busy_o && !stop_i && mode_has_writes(mode_q)
                      && !inj_pend_q && !(mem_we_o && !mem_ready_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            mode_q     <= MODE_WR_RD;
            src_q      <= SRC_LFSR;
            num_q      <= MIN_N;
            wr_cnt_q   <= '0;
            rd_iss_q   <= '0;
            rd_rcv_q   <= '0;
            inj_pend_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (start_ok) begin
                mode_q <= mtg_mode_e'(mode_i);
                src_q  <= mtg_src_e'(pat_sel_i);
                num_q  <= num_clamped;
            end
            if (wr_restart) begin
                wr_cnt_q <= '0;
            end else if (wr_fire) begin
                wr_cnt_q <= wr_cnt_q + 1'b1;
            end
            if (rd_restart) begin
                rd_iss_q <= '0;
                rd_rcv_q <= '0;
            end else begin
                if (rd_fire) rd_iss_q <= rd_iss_q + 1'b1;
                if (rv_beat) rd_rcv_q <= rd_rcv_q + 1'b1;
            end
            if (state_n == ST_IDLE) begin
                inj_pend_q <= 1'b0;
            end else if (inj_take) begin
                inj_pend_q <= 1'b1;
            end else if (wr_fire) begin
                inj_pend_q <= 1'b0;
            end
        end
    end

    // ---------------- data sources: one per side ----------------
    mtg_pattern_gen #(.ADDR_W(ADDR_W)) i_wr_src (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_restart),
        .advance (wr_fire),
        .src     (src_q),
        .addr    (wr_cnt_q[ADDR_W-1:0]),
        .word    (wr_word)
    );

    mtg_pattern_gen #(.ADDR_W(ADDR_W)) i_rd_src (
        .clk     (clk),
        .rst     (rst),
        .restart (rd_restart),
        .advance (rv_beat),
        .src     (src_q),
        .addr    (rd_rcv_q[ADDR_W-1:0]),
        .word    (rd_word)
    );

    assign mem_wdata_o = wr_word ^ {{(DATA_W-1){1'b0}}, inj_pend_q};
    assign mismatch    = rv_beat && (mem_rdata_i != rd_word);

    // ---------------- counters ----------------
    mtg_sat_counter #(.W(ERR_W)) i_err_det (
        .clk (clk), .rst (rst), .clr (clear_i), .inc (mismatch),
        .amount (ONE_ERR), .count (err_detect_o)
    );

    mtg_sat_counter #(.W(ERR_W)) i_err_ins (
        .clk (clk), .rst (rst), .clr (clear_i), .inc (inj_take),
        .amount (ONE_ERR), .count (err_insert_cnt_o)
    );

    mtg_sat_counter #(.W(BYTE_W)) i_bytes_wr (
        .clk (clk), .rst (rst), .clr (start_ok), .inc (wr_fire),
        .amount (BEAT_BYTES), .count (bytes_wr_o)
    );

    mtg_sat_counter #(.W(BYTE_W)) i_bytes_rd (
        .clk (clk), .rst (rst), .clr (start_ok), .inc (rv_beat),
        .amount (BEAT_BYTES), .count (bytes_rd_o)
    );

    // ---------------- assertions ----------------
    // R1: no port activity while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_we_o && !mem_rd_o));

    // R6: write and read strobes are exclusive
    a_r6_we_rd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we_o && mem_rd_o));

    // R7: a stalled write holds address and data
    a_r7_write_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && !mem_ready_i && !stop_i) |=>
        (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R7: a stalled read request holds its address
    a_r7_read_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !mem_ready_i && !stop_i && !mem_rvalid_i) |=>
        (mem_rd_o && $stable(mem_addr_o)));

    // R2: the latched address count stays inside the legal range
    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (num_q >= MIN_N && num_q <= MAX_N));

    // R9: the insert count moves by at most one per cycle
    a_r9_insert_step: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (err_insert_cnt_o == $past(err_insert_cnt_o)) ||
                     (err_insert_cnt_o == $past(err_insert_cnt_o) + ONE_ERR));

    // R10: an idle insert request leaves the insert count unchanged
    a_r10_idle_insert_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && err_insert_i && !clear_i) |=> $stable(err_insert_cnt_o));

    // R11: clear zeroes both error counters
    a_r11_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (err_detect_o == '0 && err_insert_cnt_o == '0));

endmodule

// File: tb/test_mem_traffic_gen.sv
`timescale 1ns/1ps
module test_mem_traffic_gen;

    localparam int AW = 24;
    localparam int EW = 32;
    localparam int BW = 8;
    localparam logic [30:0] SEED = 31'h2A5A1234;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 0, stop_i = 0, err_insert_i = 0, clear_i = 0;
    logic [1:0]    mode_i = 0, pat_sel_i = 0;
    logic [AW:0]   num_addr_i = 8;
    logic [AW-1:0] mem_addr_o;
    logic [35:0]   mem_wdata_o, mem_rdata_i;
    logic          mem_we_o, mem_rd_o, mem_ready_i, mem_rvalid_i, busy_o;
    logic [EW-1:0] err_detect_o, err_insert_cnt_o;
    logic [BW-1:0] bytes_wr_o, bytes_rd_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    mem_traffic_gen #(.ADDR_W(AW), .ERR_W(EW), .BYTE_W(BW)) i_mem_traffic_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .mode_i(mode_i), .pat_sel_i(pat_sel_i), .num_addr_i(num_addr_i),
        .err_insert_i(err_insert_i), .clear_i(clear_i),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o), .mem_rd_o(mem_rd_o), .mem_ready_i(mem_ready_i),
        .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i),
        .busy_o(busy_o), .err_detect_o(err_detect_o),
        .err_insert_cnt_o(err_insert_cnt_o),
        .bytes_wr_o(bytes_wr_o), .bytes_rd_o(bytes_rd_o)
    );

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [30:0] b_step(input logic [30:0] s);
        return {s[29:0], s[30] ^ s[27]};
    endfunction

    function automatic logic [35:0] b_word(input logic [1:0] p, input logic [30:0] s,
                                           input logic [23:0] a);
        case (p)
            2'd1:    return {9{a[3:0]}} ^ 36'h5_96A3_C0F1;
            2'd2:    return {12'h0, a} + 36'h9_C3A5_0011;
            default: return {s[4:0], s};
        endcase
    endfunction

    // ---------------- memory model ----------------
    logic [35:0] mem [64];
    logic        v1, v2, rdy_tog, stall_en = 0, spur_rv = 0;
    logic [35:0] d1, d2;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
            v1 <= 0; v2 <= 0; d1 <= '0; d2 <= '0; rdy_tog <= 0;
        end else begin
            if (mem_we_o && mem_ready_i) mem[mem_addr_o[5:0]] <= mem_wdata_o;
            v1 <= mem_rd_o && mem_ready_i;
            d1 <= mem[mem_addr_o[5:0]];
            v2 <= v1;
            d2 <= d1;
            rdy_tog <= ~rdy_tog;
        end
    end

    assign mem_ready_i  = !stall_en || rdy_tog;
    assign mem_rvalid_i = v2 || spur_rv;
    assign mem_rdata_i  = spur_rv ? 36'h0_DEAD_BEEF : d2;

    // ---------------- write monitor ----------------
    logic [1:0]  cur_pat = 0;
    logic [30:0] m_lfsr = SEED, m_s;
    logic [35:0] m_exp;
    logic        armed = 0;
    int          wcount = 0, rd_seen = 0, we_seen = 0;
    logic [23:0] max_addr = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we_o && mem_ready_i) begin
                m_s   = (mem_addr_o == 0) ? SEED : b_step(m_lfsr);
                m_exp = b_word(cur_pat, m_s, mem_addr_o) ^ {35'b0, armed};
                m_lfsr = m_s;
                if (armed)
                    chk(mem_wdata_o == m_exp, "R9 corrupted write word", mem_wdata_o, m_exp);
                else if (cur_pat == 2'd1)
                    chk(mem_wdata_o == m_exp, "R4 table write word", mem_wdata_o, m_exp);
                else if (cur_pat == 2'd2)
                    chk(mem_wdata_o == m_exp, "R5 arith write word", mem_wdata_o, m_exp);
                else
                    chk(mem_wdata_o == m_exp, "R3 lfsr write word", mem_wdata_o, m_exp);
                armed = 0;
                wcount++;
                if (mem_addr_o > max_addr) max_addr = mem_addr_o;
            end
            if (mem_rd_o) rd_seen++;
            if (mem_we_o) we_seen++;
            if (err_insert_i && busy_o) armed = 1;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            n_fail++;
            $display("FAIL R13 watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- scenario helpers ----------------
    task automatic run_start(input logic [1:0] m, input logic [1:0] p, input int n);
        @(posedge clk); #1;
        mode_i = m; pat_sel_i = p; num_addr_i = (AW+1)'(n); cur_pat = p;
        wcount = 0; rd_seen = 0; we_seen = 0; max_addr = 0;
        start_i = 1;
        @(posedge clk); #1;
        start_i = 0;
        @(negedge clk);
        chk(busy_o == 1'b1, "R13 busy after start", busy_o, 1);
    endtask

    task automatic wait_rd(input int n, input string req);
        for (int k = 0; k < 3000 && bytes_rd_o != BW'(n); k++) @(negedge clk);
        chk(bytes_rd_o == BW'(n), req, bytes_rd_o, n);
    endtask

    task automatic wait_wr(input int n);
        for (int k = 0; k < 3000 && wcount < n; k++) @(negedge clk);
    endtask

    task automatic do_stop();
        stop_i = 1;
        @(posedge clk); #1;
        stop_i = 0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R13 idle after stop", busy_o, 0);
    endtask

    task automatic pulse_clear();
        @(posedge clk); #1 clear_i = 1;
        @(posedge clk); #1 clear_i = 0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(busy_o == 0, "R1 busy at reset", busy_o, 0);
        chk(mem_we_o == 0 && mem_rd_o == 0, "R1 strobes at reset", {mem_we_o, mem_rd_o}, 0);
        chk(err_detect_o == 0 && err_insert_cnt_o == 0, "R1 error counters at reset",
            {err_detect_o, err_insert_cnt_o}, 0);
        chk(bytes_wr_o == 0 && bytes_rd_o == 0, "R1 byte counters at reset",
            {bytes_wr_o, bytes_rd_o}, 0);
    endtask

    task automatic t_write_read(input logic [1:0] p, input logic stall);
        stall_en = stall;
        run_start(2'd0, p, 8);
        wait_rd(32, "R8 one read pass in mode 0");
        chk(err_detect_o == 0, "R8 clean read-back", err_detect_o, 0);
        do_stop();
        chk(wcount >= 8, "R6 full write pass", wcount, 8);
        chk(bytes_wr_o == BW'(4 * wcount), "R12 bytes written", bytes_wr_o, 4 * wcount);
        stall_en = 0;
    endtask

    task automatic t_inject();
        pulse_clear();
        run_start(2'd0, 2'd0, 8);
        @(posedge clk); #1 err_insert_i = 1;
        @(posedge clk); #1 err_insert_i = 0;
        wait_rd(32, "R9 read pass after insert");
        chk(err_detect_o == 1, "R9 one detected error", err_detect_o, 1);
        chk(err_insert_cnt_o == 1, "R9 one inserted error", err_insert_cnt_o, 1);
        do_stop();
    endtask

    task automatic t_idle_insert();
        @(posedge clk); #1 err_insert_i = 1;
        @(posedge clk); #1 err_insert_i = 0;
        @(negedge clk);
        chk(err_insert_cnt_o == 1, "R10 idle insert count", err_insert_cnt_o, 1);
        run_start(2'd0, 2'd2, 8);
        wait_rd(32, "R10 read pass after idle insert");
        chk(err_detect_o == 1, "R10 no later corruption", err_detect_o, 1);
        do_stop();
    endtask

    task automatic t_clear();
        pulse_clear();
        @(negedge clk);
        chk(err_detect_o == 0, "R11 detected cleared", err_detect_o, 0);
        chk(err_insert_cnt_o == 0, "R11 inserted cleared", err_insert_cnt_o, 0);
    endtask

    task automatic t_wo_ro();
        logic [30:0] s;
        int          exp_mis;
        run_start(2'd2, 2'd0, 8);
        @(posedge clk); #1 spur_rv = 1;
        repeat (3) @(posedge clk);
        #1 spur_rv = 0;
        wait_wr(8);
        do_stop();
        chk(rd_seen == 0, "R6 no reads in write-only", rd_seen, 0);
        chk(bytes_rd_o == 0, "R8 stray valid not counted", bytes_rd_o, 0);
        chk(err_detect_o == 0, "R8 stray valid not compared", err_detect_o, 0);

        run_start(2'd1, 2'd0, 8);
        wait_rd(32, "R6 read-only pass");
        chk(err_detect_o == 0, "R3 lfsr read-only matches", err_detect_o, 0);
        do_stop();
        chk(we_seen == 0, "R6 no writes in read-only", we_seen, 0);

        exp_mis = 0;
        s = SEED;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) s = b_step(s);
            if (b_word(2'd0, s, 24'(i)) != b_word(2'd2, s, 24'(i))) exp_mis++;
        end
        pulse_clear();
        run_start(2'd1, 2'd2, 8);
        wait_rd(32, "R5 read-only pass arith");
        chk(err_detect_o == EW'(exp_mis), "R8 mismatch count", err_detect_o, exp_mis);
        do_stop();
    endtask

    task automatic t_clamp();
        run_start(2'd2, 2'd1, 3);
        wait_wr(12);
        do_stop();
        chk(max_addr == 24'd7, "R2 low count clamped to 8", max_addr, 7);
    endtask

    task automatic t_saturate();
        run_start(2'd2, 2'd2, 8);
        wait_wr(70);
        @(negedge clk);
        chk(bytes_wr_o == 8'hFF, "R12 byte counter saturates", bytes_wr_o, 8'hFF);
        do_stop();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_write_read(2'd0, 1'b1);
        t_write_read(2'd1, 1'b0);
        t_write_read(2'd2, 1'b1);
        t_inject();
        t_idle_insert();
        t_clear();
        t_wo_ro();
        t_clamp();
        t_saturate();
        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule